// File: doc/BRIEF.md
# Chop-Capable Third-Order Decimation Filter

This block turns a 1-bit sigma-delta bitstream into signed, decimated results with a third-order comb-integrator (sinc-cubed) low-pass filter. Each accepted bit counts as +1 or −1. Three cascaded running sums work at the sample rate, and three differencing stages work at the output rate. The decimation factor E comes from a 12-bit word, and outputs are issued every E samples once the filter has settled. The sample strobe normally pulses once per 16 master clocks, but any strobe pattern is accepted.

In chop mode the sign of the input is reversed on every other output period, and a polarity output tells the analogue front end which phase to apply. The filter is cleared at the start of every period, so each result comes only from the 3·E samples of its own period. This gives one output per 3·E samples. The period's sign is applied again to the result so that the reversal cancels. Changing the decimation word or the chop enable restarts the filter, and no result is issued until it has settled again.

Top module: `sinc3_chop_decim`

## Requirements
- R1: A sample bit of 1 counts as +1 and a bit of 0 counts as −1. Every result equals the sum over the latest 3·E accepted samples weighted by the sinc-cubed kernel: h(k) is the number of triples (a,b,c), each in 0..E−1, with a+b+c=k, and k=0 is the newest sample.
- R2: With chop disabled, after a clear the first result follows the 3·E-th accepted strobe, and one further result follows every E strobes after that.
- R3: The effective decimation E equals the SF word, except that a word of 0 is treated as 1.
- R4: With chop enabled, exactly one result follows every 3·E accepted strobes. The filter is cleared after each result, so each result uses only the samples of its own period.
- R5: With chop enabled, the polarity output starts at 0 and toggles on the edge that issues each result. Samples are negated inside the filter while polarity is 1, and results are sign-corrected, so each result equals the R1 value of the raw bits.
- R6: The polarity output stays 0 while chop is disabled.
- R7: A change of the SF word or chop enable, compared with the values held from the previous cycle, clears all filter state, counters and polarity. A strobe in that same cycle is discarded, and result timing restarts under R2 or R4.
- R8: The result is 37-bit two's complement. 3·E ones give exactly E³ and 3·E zeros give −E³, including E = 4095.
- R9: result_valid is high for one cycle, in the cycle after the edge that accepted the strobe completing the output. result holds its value between valid pulses.
- R10: While reset is applied and after it is released, result_valid is 0, result is 0 and chop_pol is 0 until the first output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| samp_en | input | 1 | Strobe: accept samp_bit in this cycle |
| samp_bit | input | 1 | Modulator bit (1 = +1, 0 = −1) |
| sf_word | input | 12 | Decimation word E (0 behaves as 1) |
| chop_en | input | 1 | Chop mode enable |
| result | output | 37 | Signed filter result |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| chop_pol | output | 1 | Current chop phase (1 = input inverted) |

## Verification
The properties assume that sf_word and chop_en change only through the clear path, so the sample counter never runs past the last index of the current window. They also assume that a polarity change is always explained by an issued result or by a clear in the cycle before. The stimulus changes configuration only at falling edges and holds it steady between changes. Strobes come every other cycle, so every result is separated by idle cycles and can be sampled without ambiguity. One directed case places a strobe on the very cycle of a configuration change to show that the sample is dropped.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  // number of integrator / comb stages (filter order)
  localparam int STAGES = 3;

  // accumulator width needed for a STAGES-order filter with an sf_w-bit factor
  function automatic int acc_width(input int sf_w);
    return STAGES * sf_w + 1;
  endfunction
endpackage

// File: rtl/s3_integ.sv
module s3_integ
  import sinc3_pkg::*;
#(
  parameter int ACC_W = 37
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic                    neg,
  output logic signed [ACC_W-1:0] last_nx
);
  logic signed [ACC_W-1:0] sum [STAGES+1];

  // +1 or -1 feeding the first running sum
  assign sum[0] = neg ? {ACC_W{1'b1}} : {{(ACC_W-1){1'b0}}, 1'b1};

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic signed [ACC_W-1:0] acc_q, acc_d;

    assign sum[g+1] = acc_q + sum[g];

    always_comb begin
      acc_d = acc_q;
      if (clr)     acc_d = '0;
      else if (en) acc_d = sum[g+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
    end
  end

  assign last_nx = sum[STAGES];
endmodule

// File: rtl/s3_comb.sv
module s3_comb
  import sinc3_pkg::*;
#(
  parameter int ACC_W = 37
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    fire,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] dout
);
  logic signed [ACC_W-1:0] diff [STAGES+1];

  assign diff[0] = din;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic signed [ACC_W-1:0] dly_q, dly_d;

    assign diff[g+1] = diff[g] - dly_q;

    always_comb begin
      dly_d = dly_q;
      if (clr)       dly_d = '0;
      else if (fire) dly_d = diff[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly_q <= '0;
      else        dly_q <= dly_d;
    end
  end

  assign dout = diff[STAGES];
endmodule

// File: rtl/s3_ctrl.sv
module s3_ctrl #(
  parameter int SF_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            samp_en,
  input  logic [SF_W-1:0] sf_word,
  input  logic            chop_en,
  output logic            take,
  output logic            fire,
  output logic            emit,
  output logic            clr,
  output logic            cfg_chg,
  output logic            chop_q,
  output logic            pol_q,
  output logic [SF_W-1:0] scnt_q,
  output logic [SF_W-1:0] last_idx
);
  localparam int DC_W = 2;
  localparam logic [DC_W-1:0] DC_FULL = DC_W'(3);

  logic [SF_W-1:0] sf_q, sf_d, scnt_d;
  logic [DC_W-1:0] dcnt_q, dcnt_d;
  logic            chop_d, pol_d, flush;

  assign cfg_chg  = (sf_word != sf_q) || (chop_en != chop_q);
  assign last_idx = (sf_q == '0) ? '0 : sf_q - 1'b1;
  assign take     = samp_en && !cfg_chg;
  assign fire     = take && (scnt_q == last_idx);
  // third and later window ends carry a fully settled result
  assign emit     = fire && dcnt_q[1];
  assign flush    = emit && chop_q;
  assign clr      = cfg_chg || flush;

  always_comb begin
    sf_d   = sf_word;
    chop_d = chop_en;
    scnt_d = scnt_q;
    dcnt_d = dcnt_q;
    pol_d  = pol_q;
    if (cfg_chg) begin
      scnt_d = '0;
      dcnt_d = '0;
      pol_d  = 1'b0;
    end else if (fire) begin
      scnt_d = '0;
      if (flush) begin
        dcnt_d = '0;
        pol_d  = !pol_q;
      end else if (dcnt_q != DC_FULL) begin
        dcnt_d = dcnt_q + 1'b1;
      end
    end else if (take) begin
      scnt_d = scnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_q   <= '0;
      chop_q <= 1'b0;
      scnt_q <= '0;
      dcnt_q <= '0;
      pol_q  <= 1'b0;
    end else begin
      sf_q   <= sf_d;
      chop_q <= chop_d;
      scnt_q <= scnt_d;
      dcnt_q <= dcnt_d;
      pol_q  <= pol_d;
    end
  end
endmodule

// File: rtl/sinc3_chop_decim.sv
module sinc3_chop_decim
  import sinc3_pkg::*;
#(
  parameter int SF_W  = 12,
  parameter int ACC_W = acc_width(SF_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    samp_en,
  input  logic                    samp_bit,
  input  logic [SF_W-1:0]         sf_word,
  input  logic                    chop_en,
  output logic signed [ACC_W-1:0] result,
  output logic                    result_valid,
  output logic                    chop_pol
);
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic            ctl_take, ctl_fire, ctl_emit, ctl_clr, ctl_chg, ctl_chop, ctl_pol;
  logic [SF_W-1:0] ctl_scnt, ctl_last;
  logic signed [ACC_W-1:0] integ_nx, comb_out;

  s3_ctrl #(.SF_W(SF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_q), .samp_en(samp_en), .sf_word(sf_word),
    .chop_en(chop_en), .take(ctl_take), .fire(ctl_fire), .emit(ctl_emit),
    .clr(ctl_clr), .cfg_chg(ctl_chg), .chop_q(ctl_chop), .pol_q(ctl_pol),
    .scnt_q(ctl_scnt), .last_idx(ctl_last)
  );

  s3_integ #(.ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst_n(rst_q), .clr(ctl_clr), .en(ctl_take),
    .neg(!samp_bit ^ (ctl_chop && ctl_pol)), .last_nx(integ_nx)
  );

  s3_comb #(.ACC_W(ACC_W)) u_comb (
    .clk(clk), .rst_n(rst_q), .clr(ctl_clr), .fire(ctl_fire),
    .din(integ_nx), .dout(comb_out)
  );

  logic signed [ACC_W-1:0] res_d;
  logic                    vld_d;

  always_comb begin
    res_d = result;
    vld_d = ctl_emit;
    if (ctl_emit) res_d = (ctl_chop && ctl_pol) ? -comb_out : comb_out;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result       <= res_d;
      result_valid <= vld_d;
    end
  end

  assign chop_pol = ctl_pol;
endmodule

// File: rtl/s3_chk.sv
module s3_chk #(
  parameter int SF_W  = 12,
  parameter int ACC_W = 37
) (
  input logic                    clk,
  input logic                    rst_q,
  input logic                    ctl_chg,
  input logic                    ctl_chop,
  input logic                    ctl_pol,
  input logic [SF_W-1:0]         ctl_scnt,
  input logic [SF_W-1:0]         ctl_last,
  input logic                    result_valid,
  input logic signed [ACC_W-1:0] result
);
  localparam longint MAXE = (longint'(1) << SF_W) - 1;
  localparam logic signed [ACC_W-1:0] LIM = ACC_W'(MAXE * MAXE * MAXE);

  // R3: the sample counter never passes the last index of the window
  p_scnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_q)
    ctl_scnt <= ctl_last);

  // R5: every chop result comes with a polarity flip
  p_pol_flip_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (result_valid && ctl_chop) |-> (ctl_pol != $past(ctl_pol)));

  // R5: polarity moves only on a result or after a clear
  p_pol_cause_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (ctl_pol != $past(ctl_pol)) |-> (result_valid || $past(ctl_chg)));

  // R6: no polarity while chop is off
  p_pol_off_r6: assert property (@(posedge clk) disable iff (!rst_q)
    !ctl_chop |-> !ctl_pol);

  // R7: a configuration change never produces a result on the next cycle
  p_no_valid_after_chg_r7: assert property (@(posedge clk) disable iff (!rst_q)
    $past(ctl_chg) |-> !result_valid);

  // R8: result magnitude never exceeds full scale
  p_range_r8: assert property (@(posedge clk) disable iff (!rst_q)
    result_valid |-> ((result <= LIM) && (result >= -LIM)));
endmodule

bind sinc3_chop_decim s3_chk #(.SF_W(SF_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_q(rst_q), .ctl_chg(ctl_chg), .ctl_chop(ctl_chop),
  .ctl_pol(ctl_pol), .ctl_scnt(ctl_scnt), .ctl_last(ctl_last),
  .result_valid(result_valid), .result(result)
);

// File: tb/sim_sinc3_chop_decim.sv
`timescale 1ns/1ps
module sim_sinc3_chop_decim;
  localparam int SF_W = 12;
  localparam int ACC_W = 37;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic samp_en = 1'b0;
  logic samp_bit = 1'b0;
  logic [SF_W-1:0] sf_word = 12'd4;
  logic chop_en = 1'b0;
  logic signed [ACC_W-1:0] result;
  logic result_valid, chop_pol;

  always #2 clk = ~clk;

  sinc3_chop_decim #(.SF_W(SF_W)) u0 (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .samp_bit(samp_bit),
    .sf_word(sf_word), .chop_en(chop_en), .result(result),
    .result_valid(result_valid), .chop_pol(chop_pol)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model state
  int m_e, m_n, m_scnt, m_dec;
  bit m_chop, m_pol;
  int hist [1024];
  longint m_last;

  // row: sf[25:14] chop[13] pattern[12:10] samples[9:0]
  localparam int NROW = 6;
  localparam logic [25:0] ROWS [NROW] = '{
    {12'd4, 1'b0, 3'd2, 10'd60},
    {12'd5, 1'b1, 3'd3, 10'd60},
    {12'd1, 1'b0, 3'd1, 10'd12},
    {12'd0, 1'b0, 3'd2, 10'd12},
    {12'd3, 1'b1, 3'd2, 10'd45},
    {12'd7, 1'b0, 3'd3, 10'd80}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint wgt(input int k, input int s);
    longint c = 0;
    for (int a = 0; a < s; a++)
      for (int b = 0; b < s; b++)
        if ((k - a - b) >= 0 && (k - a - b) < s) c++;
    return c;
  endfunction

  function automatic bit pat_bit(input int kind, input int idx);
    case (kind)
      0: return 1'b1;
      1: return idx[0];
      2: return ((idx * 7) % 5) < 2;
      3: return (idx % 3) != 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_clear(input int sf, input bit chop);
    m_e = (sf == 0) ? 1 : sf;
    m_chop = chop;
    m_n = 0; m_scnt = 0; m_dec = 0; m_pol = 1'b0;
  endtask

  // drive one strobe; optionally compare with the model
  task automatic step(input bit b, input bit use_model);
    bit ev;
    longint ex;
    @(negedge clk);
    samp_en = 1'b1; samp_bit = b;
    @(negedge clk);
    samp_en = 1'b0;
    if (!use_model) return;
    ev = 1'b0; ex = 0;
    hist[m_n] = b ? 1 : -1;
    m_n++; m_scnt++;
    if (m_scnt == m_e) begin
      m_scnt = 0; m_dec++;
      if (m_dec >= 3) begin
        ev = 1'b1;
        for (int k = 0; k <= 3 * m_e - 3; k++) ex += wgt(k, m_e) * hist[m_n - 1 - k];
        if (m_chop) begin m_pol = !m_pol; m_n = 0; m_dec = 0; end
      end
    end
    chk(result_valid == ev, m_chop ? "R4 valid timing" : "R2 valid timing", result_valid, ev);
    if (ev) begin
      chk(longint'(result) == ex, (m_e == 1) ? "R3 value" : (m_chop ? "R5 value" : "R1 value"),
          longint'(result), ex);
      m_last = ex;
    end else begin
      chk(longint'(result) == m_last, "R9 hold", longint'(result), m_last);
    end
    chk(chop_pol == m_pol, m_chop ? "R5 polarity" : "R6 polarity", chop_pol, m_pol);
  endtask

  task automatic do_reset(input int sf, input bit chop);
    @(negedge clk);
    rst_n = 1'b0; samp_en = 1'b0;
    sf_word = SF_W'(sf); chop_en = chop;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_clear(sf, chop);
    m_last = 0;
  endtask

  task automatic set_cfg(input int sf, input bit chop);
    @(negedge clk);
    if (sf != int'(sf_word) || chop != chop_en) model_clear(sf, chop);
    sf_word = SF_W'(sf); chop_en = chop;
    @(negedge clk);
  endtask

  initial begin
    int early;
    longint fs;
    // R10: reset state
    repeat (2) @(negedge clk);
    chk(result_valid == 1'b0, "R10 valid in reset", result_valid, 0);
    chk(result == '0, "R10 result in reset", longint'(result), 0);
    chk(chop_pol == 1'b0, "R10 polarity in reset", chop_pol, 0);
    do_reset(4, 1'b0);
    chk(result_valid == 1'b0 && result == '0 && chop_pol == 1'b0,
        "R10 after release", longint'(result), 0);

    // table-driven runs
    for (int r = 0; r < NROW; r++) begin
      do_reset(int'(ROWS[r][25:14]), ROWS[r][13]);
      for (int i = 0; i < int'(ROWS[r][9:0]); i++)
        step(pat_bit(int'(ROWS[r][12:10]), i), 1'b1);
    end

    // R7: change mid-window with a strobe in the same cycle
    do_reset(4, 1'b0);
    for (int i = 0; i < 7; i++) step(pat_bit(2, i), 1'b1);
    @(negedge clk);
    sf_word = 12'd6; samp_en = 1'b1; samp_bit = 1'b1;
    @(negedge clk);
    samp_en = 1'b0;
    chk(result_valid == 1'b0, "R7 no result after change", result_valid, 0);
    model_clear(6, 1'b0);
    for (int i = 0; i < 18; i++) step(pat_bit(3, i), 1'b1);
    // R7: enabling chop restarts, then disabling clears polarity
    set_cfg(6, 1'b1);
    for (int i = 0; i < 20; i++) step(pat_bit(1, i), 1'b1);
    chk(chop_pol == 1'b1, "R5 polarity after first chop result", chop_pol, 1);
    set_cfg(6, 1'b0);
    chk(chop_pol == 1'b0, "R7 polarity cleared", chop_pol, 0);

    // R8: full scale positive, largest factor, chop off
    do_reset(4095, 1'b0);
    fs = 64'd4095 * 64'd4095 * 64'd4095;
    early = 0;
    for (int i = 0; i < 3 * 4095 - 1; i++) begin
      step(1'b1, 1'b0);
      if (result_valid) early++;
    end
    chk(early == 0, "R8 no early result", early, 0);
    step(1'b1, 1'b0);
    chk(result_valid == 1'b1, "R8 valid at full window", result_valid, 1);
    chk(longint'(result) == fs, "R8 positive full scale", longint'(result), fs);

    // R8: full scale negative, chop on
    do_reset(4095, 1'b1);
    early = 0;
    for (int i = 0; i < 3 * 4095 - 1; i++) begin
      step(1'b0, 1'b0);
      if (result_valid) early++;
    end
    chk(early == 0, "R8 no early chop result", early, 0);
    step(1'b0, 1'b0);
    chk(result_valid == 1'b1, "R8 chop valid", result_valid, 1);
    chk(longint'(result) == -fs, "R8 negative full scale", longint'(result), -fs);
    chk(chop_pol == 1'b1, "R5 polarity toggled", chop_pol, 1);
    @(negedge clk);
    chk(result_valid == 1'b0, "R9 single-cycle valid", result_valid, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule